// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits between a host write port and the control engine of a flash array. It watches host writes, each carrying an address and a data byte, and recognises multi-write command sequences. Every sequence has to open with a fixed two-write unlock pattern. A third write to a fixed command address then carries the command code. Erase and sector-protection commands also need a setup code, a second unlock pair and a final write. Recognised sequences change the read-path mode select (array, identifier or status) or raise a one-clock request toward the program/erase engine. For sector commands, the sector number is captured from the upper address bits of the final write.

A busy input from the engine restricts what is accepted. While it is high, only the status-read and abort commands take effect. Any write that departs from the expected pattern drops the decoder back to idle, and no request is issued. Timing on the host bus, the operations themselves and the array lie outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (`rd_mode` = 2'b00), every request output is low and `sect_addr` is zero.
- R2: The unlock pattern is data AAh at address 5555h followed by data 55h at address 2AAAh. Only address bits 14..0 are compared, so bits 19..15 of the unlock and command writes are ignored.
- R3: A third write to 5555h with code F0h selects array read (2'b00), 90h selects identifier read (2'b01) and 70h selects status read (2'b10). The new mode appears one clock after the write.
- R4: A third write of A0h to 5555h pulses `req_prog` and sets the read mode to status.
- R5: A third write of 50h to 5555h pulses `req_clr_status` and leaves the read mode unchanged. E0h pulses `req_abort` and sets the read mode to status.
- R6: Setup code 80h, then a second unlock pair, then either 10h at 5555h (pulses `req_chip_erase`) or 30h at any address (pulses `req_sect_erase`). Sector erase latches address bits 19..15 into `sect_addr`. Both commands set the read mode to status.
- R7: Setup code 60h, then a second unlock pair, then 20h (pulses `req_protect`) or 40h (pulses `req_unprotect`). These are accepted only when address bits 19..15 of the final write are 00000b or 11111b. Accepted commands latch the sector and set status mode. An illegal sector issues nothing and leaves mode and `sect_addr` unchanged.
- R8: A write that breaks the expected pattern, whether by a wrong address, a wrong data byte or an unknown code, returns the decoder to idle with no request. The next command needs a fresh unlock pair.
- R9: While `busy` is high, only 70h (status read) and E0h (abort) are honoured. Every other command, including F0h and the final write of an erase or protect sequence, is dropped, and mode and requests are unaffected.
- R10: Each request is high for exactly one clock, one clock after the final write, and at most one request is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one write per clock it is high |
| wr_addr | input | 20 | Host write address |
| wr_data | input | 8 | Host write data byte |
| busy | input | 1 | Program/erase engine is running |
| rd_mode | output | 2 | Read path select: 00 array, 01 identifier, 10 status |
| req_prog | output | 1 | Page program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sect_erase | output | 1 | Sector erase request pulse |
| req_protect | output | 1 | Sector protect request pulse |
| req_unprotect | output | 1 | Sector unprotect request pulse |
| req_clr_status | output | 1 | Clear status request pulse |
| req_abort | output | 1 | Abort request pulse |
| sect_addr | output | 5 | Sector number latched from the last accepted sector command |

## Verification
Every result of this block, whether a mode change, a request pulse or a new sector number, is registered. It is due on the first rising edge after the clock in which the final write of a sequence is presented. The bench drives writes on falling edges. Its behavioural model consumes the same write at the rising edge, and the outputs are compared shortly after that edge, so each pulse is checked in the one cycle it should occupy and is absent in all others. Because reset release passes through a two-stage synchroniser, the bench holds off writes for several clocks after deasserting reset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UNL1,
    S_CMD,
    S_ER_A,
    S_ER_B,
    S_ER_FIN,
    S_PR_A,
    S_PR_B,
    S_PR_FIN
  } dec_state_t;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'b00,
    MODE_IDENT  = 2'b01,
    MODE_STATUS = 2'b10
  } rd_mode_t;

  localparam int CMP_W  = 15;
  localparam int CODE_W = 8;

  localparam logic [CMP_W-1:0] ADDR_KEY_A = 15'h5555;
  localparam logic [CMP_W-1:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [CODE_W-1:0] KEY_A       = 8'hAA;
  localparam logic [CODE_W-1:0] KEY_B       = 8'h55;
  localparam logic [CODE_W-1:0] OP_ARRAY    = 8'hF0;
  localparam logic [CODE_W-1:0] OP_IDENT    = 8'h90;
  localparam logic [CODE_W-1:0] OP_STATUS   = 8'h70;
  localparam logic [CODE_W-1:0] OP_PROG     = 8'hA0;
  localparam logic [CODE_W-1:0] OP_CLEAR    = 8'h50;
  localparam logic [CODE_W-1:0] OP_ABORT    = 8'hE0;
  localparam logic [CODE_W-1:0] OP_ER_SETUP = 8'h80;
  localparam logic [CODE_W-1:0] OP_PR_SETUP = 8'h60;
  localparam logic [CODE_W-1:0] OP_CHIP     = 8'h10;
  localparam logic [CODE_W-1:0] OP_SECT     = 8'h30;
  localparam logic [CODE_W-1:0] OP_LOCK     = 8'h20;
  localparam logic [CODE_W-1:0] OP_UNLOCK   = 8'h40;

  localparam int REQ_PROG   = 0;
  localparam int REQ_CHIP   = 1;
  localparam int REQ_SECT   = 2;
  localparam int REQ_LOCK   = 3;
  localparam int REQ_UNLOCK = 4;
  localparam int REQ_CLEAR  = 5;
  localparam int REQ_ABORT  = 6;
  localparam int N_REQ      = 7;

endpackage

// File: rtl/flash_cmd_rst_sync.sv
module flash_cmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [CODE_W-1:0] data,
  output logic              hit_key_a,
  output logic              hit_key_b,
  output logic              at_cmd_addr
);
  logic at_a, at_b;

  always_comb begin
    at_a        = (addr_lo == ADDR_KEY_A);
    at_b        = (addr_lo == ADDR_KEY_B);
    at_cmd_addr = at_a;
    hit_key_a   = at_a && (data == KEY_A);
    hit_key_b   = at_b && (data == KEY_B);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic              hit_key_a,
  input  logic              hit_key_b,
  input  logic              at_cmd_addr,
  input  logic [CODE_W-1:0] code,
  input  logic [SECT_W-1:0] sect_in,
  output rd_mode_t          mode,
  output logic [N_REQ-1:0]  req,
  output logic [SECT_W-1:0] sect
);
  dec_state_t        state_q, state_d;
  rd_mode_t          mode_q, mode_d;
  logic [N_REQ-1:0]  req_q, req_d;
  logic [SECT_W-1:0] sect_q;
  logic              sect_we;
  logic              sect_edge;

  assign sect_edge = (&sect_in) || (~|sect_in);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    req_d   = '0;
    sect_we = 1'b0;
    if (wr_en) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE:  if (hit_key_a) state_d = S_UNL1;
        S_UNL1:  if (hit_key_b) state_d = S_CMD;
        S_CMD: begin
          if (at_cmd_addr) begin
            if (code == OP_STATUS) begin
              mode_d = MODE_STATUS;
            end else if (code == OP_ABORT) begin
              req_d[REQ_ABORT] = 1'b1;
              mode_d           = MODE_STATUS;
            end else if (!busy) begin
              case (code)
                OP_ARRAY:    mode_d = MODE_ARRAY;
                OP_IDENT:    mode_d = MODE_IDENT;
                OP_PROG: begin
                  req_d[REQ_PROG] = 1'b1;
                  mode_d          = MODE_STATUS;
                end
                OP_CLEAR:    req_d[REQ_CLEAR] = 1'b1;
                OP_ER_SETUP: state_d = S_ER_A;
                OP_PR_SETUP: state_d = S_PR_A;
                default:     state_d = S_IDLE;
              endcase
            end
          end
        end
        S_ER_A:  if (hit_key_a) state_d = S_ER_B;
        S_ER_B:  if (hit_key_b) state_d = S_ER_FIN;
        S_ER_FIN: begin
          if (!busy) begin
            if (code == OP_CHIP && at_cmd_addr) begin
              req_d[REQ_CHIP] = 1'b1;
              mode_d          = MODE_STATUS;
            end else if (code == OP_SECT) begin
              req_d[REQ_SECT] = 1'b1;
              mode_d          = MODE_STATUS;
              sect_we         = 1'b1;
            end
          end
        end
        S_PR_A:  if (hit_key_a) state_d = S_PR_B;
        S_PR_B:  if (hit_key_b) state_d = S_PR_FIN;
        S_PR_FIN: begin
          if (!busy && sect_edge) begin
            if (code == OP_LOCK) begin
              req_d[REQ_LOCK] = 1'b1;
              mode_d          = MODE_STATUS;
              sect_we         = 1'b1;
            end else if (code == OP_UNLOCK) begin
              req_d[REQ_UNLOCK] = 1'b1;
              mode_d            = MODE_STATUS;
              sect_we           = 1'b1;
            end
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= MODE_ARRAY;
      req_q   <= '0;
      sect_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      req_q   <= req_d;
      if (sect_we) sect_q <= sect_in;
    end
  end

  assign mode = mode_q;
  assign req  = req_q;
  assign sect = sect_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic [1:0]        rd_mode,
  output logic              req_prog,
  output logic              req_chip_erase,
  output logic              req_sect_erase,
  output logic              req_protect,
  output logic              req_unprotect,
  output logic              req_clr_status,
  output logic              req_abort,
  output logic [SECT_W-1:0] sect_addr
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic             rst_n_int;
  logic             hit_a, hit_b, at_cmd;
  rd_mode_t         mode;
  logic [N_REQ-1:0] req;

  flash_cmd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  flash_cmd_match u_match (
    .addr_lo(wr_addr[CMP_W-1:0]),
    .data(wr_data),
    .hit_key_a(hit_a),
    .hit_key_b(hit_b),
    .at_cmd_addr(at_cmd)
  );

  flash_cmd_fsm #(.SECT_W(SECT_W)) u_fsm (
    .clk(clk),
    .rst_n(rst_n_int),
    .wr_en(wr_en),
    .busy(busy),
    .hit_key_a(hit_a),
    .hit_key_b(hit_b),
    .at_cmd_addr(at_cmd),
    .code(wr_data),
    .sect_in(wr_addr[ADDR_W-1:SECT_LSB]),
    .mode(mode),
    .req(req),
    .sect(sect_addr)
  );

  assign rd_mode        = mode;
  assign req_prog       = req[REQ_PROG];
  assign req_chip_erase = req[REQ_CHIP];
  assign req_sect_erase = req[REQ_SECT];
  assign req_protect    = req[REQ_LOCK];
  assign req_unprotect  = req[REQ_UNLOCK];
  assign req_clr_status = req[REQ_CLEAR];
  assign req_abort      = req[REQ_ABORT];
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int SECT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic [1:0]        rd_mode,
  input logic              req_prog,
  input logic              req_chip_erase,
  input logic              req_sect_erase,
  input logic              req_protect,
  input logic              req_unprotect,
  input logic              req_clr_status,
  input logic              req_abort,
  input logic [SECT_W-1:0] sect_addr
);
  logic [6:0] reqs;
  assign reqs = {req_abort, req_clr_status, req_unprotect, req_protect,
                 req_sect_erase, req_chip_erase, req_prog};

  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs));

  p_req_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (reqs == 7'b0));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> !(req_prog || req_chip_erase || req_sect_erase ||
                          req_protect || req_unprotect || req_clr_status));

  p_prot_edge_sector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_protect || req_unprotect) |-> ((&sect_addr) || (sect_addr == '0)));

  p_status_after_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_chip_erase || req_sect_erase || req_protect ||
     req_unprotect || req_abort) |-> (rd_mode == 2'b10));

  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'b11);

  p_idle_mode_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_mode));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .rd_mode(rd_mode),
  .req_prog(req_prog), .req_chip_erase(req_chip_erase),
  .req_sect_erase(req_sect_erase), .req_protect(req_protect),
  .req_unprotect(req_unprotect), .req_clr_status(req_clr_status),
  .req_abort(req_abort), .sect_addr(sect_addr)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [1:0]  rd_mode;
  logic        req_prog, req_chip_erase, req_sect_erase, req_protect;
  logic        req_unprotect, req_clr_status, req_abort;
  logic [4:0]  sect_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  int         m_phase = 0;
  logic [1:0] m_mode = 2'b00;
  logic [6:0] m_req = '0;
  logic [4:0] m_sect = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_mode(rd_mode),
    .req_prog(req_prog), .req_chip_erase(req_chip_erase),
    .req_sect_erase(req_sect_erase), .req_protect(req_protect),
    .req_unprotect(req_unprotect), .req_clr_status(req_clr_status),
    .req_abort(req_abort), .sect_addr(sect_addr)
  );

  function automatic logic [6:0] dut_reqs();
    return {req_abort, req_clr_status, req_unprotect, req_protect,
            req_sect_erase, req_chip_erase, req_prog};
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped at each rising edge
  always @(posedge clk) begin
    int a;
    int d;
    int s;
    int nxt;
    if (!rst_n) begin
      m_phase = 0; m_mode = 2'b00; m_req = '0; m_sect = '0;
    end else begin
      m_req = '0;
      if (wr_en) begin
        a = int'(wr_addr[14:0]); d = int'(wr_data); s = int'(wr_addr[19:15]);
        nxt = 0;
        case (m_phase)
          0, 3, 6: if (a == 'h5555 && d == 'hAA) nxt = m_phase + 1;
          1, 4, 7: if (a == 'h2AAA && d == 'h55) nxt = m_phase + 1;
          2: if (a == 'h5555) begin
               if (d == 'h70) m_mode = 2'b10;
               else if (d == 'hE0) begin m_req[6] = 1'b1; m_mode = 2'b10; end
               else if (!busy) begin
                 if (d == 'hF0) m_mode = 2'b00;
                 else if (d == 'h90) m_mode = 2'b01;
                 else if (d == 'hA0) begin m_req[0] = 1'b1; m_mode = 2'b10; end
                 else if (d == 'h50) m_req[5] = 1'b1;
                 else if (d == 'h80) nxt = 3;
                 else if (d == 'h60) nxt = 6;
               end
             end
          5: if (!busy) begin
               if (d == 'h10 && a == 'h5555) begin m_req[1] = 1'b1; m_mode = 2'b10; end
               else if (d == 'h30) begin m_req[2] = 1'b1; m_mode = 2'b10; m_sect = 5'(s); end
             end
          8: if (!busy && (s == 0 || s == 31) && (d == 'h20 || d == 'h40)) begin
               if (d == 'h20) m_req[3] = 1'b1; else m_req[4] = 1'b1;
               m_mode = 2'b10; m_sect = 5'(s);
             end
          default: nxt = 0;
        endcase
        m_phase = nxt;
      end
    end
    #2;
    if (cmp_on) begin
      check({cur_req, " rd_mode"}, int'(rd_mode), int'(m_mode));
      check({cur_req, " R10 requests"}, int'(dut_reqs()), int'(m_req));
      check({cur_req, " sect_addr"}, int'(sect_addr), int'(m_sect));
    end
  end

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic unlock();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  task automatic cmd(input logic [7:0] c);
    unlock();
    wr(20'h05555, c);
  endtask

  task automatic long_cmd(input logic [7:0] setup, input logic [19:0] a,
                          input logic [7:0] c);
    cmd(setup);
    unlock();
    wr(a, c);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    cur_req = "R1";
    check("R1 reset mode", int'(rd_mode), 0);
    check("R1 reset requests", int'(dut_reqs()), 0);
    check("R1 reset sector", int'(sect_addr), 0);

    cur_req = "R3";
    cmd(8'h90); check("R3 ident mode", int'(rd_mode), 1);
    cmd(8'h70); check("R3 status mode", int'(rd_mode), 2);
    cmd(8'hF0); check("R3 array mode", int'(rd_mode), 0);

    cur_req = "R2";
    wr(20'hF5555, 8'hAA); wr(20'hA2AAA, 8'h55); wr(20'h35555, 8'h90);
    check("R2 upper bits ignored", int'(rd_mode), 1);
    cmd(8'hF0);

    cur_req = "R4";
    cmd(8'hA0);
    check("R4 program pulse", int'(req_prog), 1);
    check("R4 status mode", int'(rd_mode), 2);
    @(negedge clk); check("R4 pulse one cycle", int'(req_prog), 0);

    cur_req = "R5";
    cmd(8'h90);
    cmd(8'h50);
    check("R5 clear pulse", int'(req_clr_status), 1);
    check("R5 mode kept", int'(rd_mode), 1);
    cmd(8'hE0);
    check("R5 abort pulse", int'(req_abort), 1);
    check("R5 abort status", int'(rd_mode), 2);

    cur_req = "R6";
    cmd(8'hF0);
    long_cmd(8'h80, 20'h05555, 8'h10);
    check("R6 chip erase", int'(req_chip_erase), 1);
    check("R6 status mode", int'(rd_mode), 2);
    long_cmd(8'h80, 20'hA8123, 8'h30);
    check("R6 sector erase", int'(req_sect_erase), 1);
    check("R6 sector latched", int'(sect_addr), 'h15);

    cur_req = "R7";
    cmd(8'hF0);
    long_cmd(8'h60, 20'h00000, 8'h20);
    check("R7 protect low", int'(req_protect), 1);
    check("R7 sector zero", int'(sect_addr), 0);
    long_cmd(8'h60, 20'hF8000, 8'h40);
    check("R7 unprotect high", int'(req_unprotect), 1);
    check("R7 sector ones", int'(sect_addr), 31);
    cmd(8'hF0);
    long_cmd(8'h60, 20'h40000, 8'h20);
    check("R7 illegal sector no pulse", int'(req_protect), 0);
    check("R7 illegal sector mode", int'(rd_mode), 0);
    check("R7 illegal sector kept", int'(sect_addr), 31);

    cur_req = "R8";
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h54); wr(20'h05555, 8'h90);
    check("R8 broken data", int'(rd_mode), 0);
    wr(20'h05555, 8'hAA); wr(20'h02AAB, 8'h55); wr(20'h05555, 8'hA0);
    check("R8 broken address", int'(req_prog), 0);
    cmd(8'h33); wr(20'h05555, 8'h90);
    check("R8 unknown code then bare write", int'(rd_mode), 0);
    cmd(8'h80); wr(20'h05555, 8'hAA); wr(20'h05555, 8'h10);
    check("R8 broken second unlock", int'(req_chip_erase), 0);

    cur_req = "R9";
    cmd(8'h90);
    @(negedge clk); busy = 1'b1;
    cmd(8'hF0); check("R9 reset ignored", int'(rd_mode), 1);
    cmd(8'hA0); check("R9 program ignored", int'(req_prog), 0);
    check("R9 mode after program", int'(rd_mode), 1);
    cmd(8'h50); check("R9 clear ignored", int'(req_clr_status), 0);
    cmd(8'h70); check("R9 status honoured", int'(rd_mode), 2);
    cmd(8'hE0); check("R9 abort honoured", int'(req_abort), 1);
    cmd(8'h80); cmd(8'h10);
    check("R9 erase setup ignored", int'(req_chip_erase), 0);
    @(negedge clk); busy = 1'b0;
    cmd(8'h80); unlock();
    @(negedge clk); busy = 1'b1;
    wr(20'h05555, 8'h10);
    check("R9 final write dropped", int'(req_chip_erase), 0);
    @(negedge clk); busy = 1'b0;

    cur_req = "R10";
    cmd(8'hF0);
    long_cmd(8'h80, 20'h28000, 8'h30);
    check("R10 pulse present", int'(req_sect_erase), 1);
    @(negedge clk);
    check("R10 pulse gone", int'(req_sect_erase), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule